// File: doc/BRIEF.md
# Quantized Shift and Byte-Swap Unit

This execution unit serves a 16-bit core whose general-purpose registers are 24 bits wide. Each cycle it takes a 2-bit operation select, a destination operand, a source operand and a shift count, and it produces a 24-bit result and three status flags. The count comes either from a 7-bit immediate or from the source operand. The supported operations are logical right shift, left shift, arithmetic right shift and a byte swap of the source operand.

Only the low 16 bits of a register take part in a shift. Bits 23..16 of every result are forced to zero. The shift count is not used as given: 0 to 3 shift by exactly that many places, 4 to 7 shift by 4, and any larger count shifts by 8.

The result and the flags are captured in output registers, so each operation shows one clock after its inputs are presented. Decode, register file access and writeback belong to the surrounding pipeline and are not part of this unit.

Top module: `shswUnit`

## Requirements
- R1: The outputs are registered and appear on the clock edge after their inputs are presented. While rstN is low, result, flagC, flagZ, flagN and flagWe are all 0.
- R2: Bits 23..16 of result are 0 for every operation, whatever the upper bits of either operand hold.
- R3: The requested count selects the effective shift. A count of 0, 1, 2 or 3 shifts by that amount, 4 through 7 shift by 4, and 8 or more shifts by 8. A count taken from the source operand compares only srcOpnd[15:0] against these limits.
- R4: opSel 2'b00 shifts dstOpnd[15:0] right by the effective count and fills the vacated high bits with zeros.
- R5: opSel 2'b01 shifts dstOpnd[15:0] left by the effective count and fills the vacated low bits with zeros.
- R6: opSel 2'b10 shifts dstOpnd[15:0] right by the effective count and copies dstOpnd[15] into every vacated high bit.
- R7: opSel 2'b11 places srcOpnd[7:0] in result[15:8] and srcOpnd[15:8] in result[7:0]. The destination operand and the count have no effect on the result.
- R8: For a shift, flagC holds the last bit moved out of the 16-bit field. This is bit k-1 of the field for a right shift by k and bit 16-k for a left shift by k. flagC is 0 when the effective count is 0.
- R9: For a shift, flagZ is 1 exactly when result[15:0] is zero, and flagN equals result[15].
- R10: flagWe is 1 after any shift and 0 after a swap. After a swap, flagC, flagZ and flagN read 0.
- R11: useImm = 1 takes the count from immCnt. useImm = 0 takes it from srcOpnd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opSel | input | 2 | 00 logical right, 01 left, 10 arithmetic right, 11 byte swap |
| dstOpnd | input | 24 | Destination register value; this operand is shifted |
| srcOpnd | input | 24 | Source register value; used as the swap operand or as the shift count |
| immCnt | input | 7 | Immediate shift count |
| useImm | input | 1 | 1 selects immCnt as the count, 0 selects srcOpnd |
| result | output | 24 | Registered result |
| flagC | output | 1 | Registered carry (last bit shifted out) |
| flagZ | output | 1 | Registered zero flag |
| flagN | output | 1 | Registered negative flag |
| flagWe | output | 1 | Registered flag-update enable |

## Verification
The boundaries that are hardest to reach are in the count quantizer. Random register counts almost never land in the range 0 to 12, and they almost always have nonzero upper bits. A register count with junk in bits 23..16 above a small low half is rarer still, and it is the case that shows the upper bits are ignored. The stimulus therefore biases half of the random register counts into the range 0 to 11. It also runs a directed sweep over every count from 0 to 9 for both count sources, plus register counts of 0xFFFF, 0x0008 and 0x3F0002.

// File: rtl/shswPkg.sv
package shswPkg;

  localparam int AMT_W = 4;

  typedef enum logic [1:0] {
    OP_SRL  = 2'b00,
    OP_SL   = 2'b01,
    OP_SRA  = 2'b10,
    OP_SWAP = 2'b11
  } shOp_e;

  typedef struct packed {
    logic [AMT_W-1:0] amount;
    logic             goRight;
    logic             fillSign;
    logic             doSwap;
    logic             flagEn;
  } shCtrl_t;

endpackage

// File: rtl/shswCtrl.sv
module shswCtrl
  import shswPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IMM_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       opSel,
  input  logic             useImm,
  input  logic [IMM_W-1:0] immCnt,
  input  logic [CNT_W-1:0] regCnt,
  output shCtrl_t          ctrl
);

  localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'(4);
  localparam logic [CNT_W-1:0] LIM_HIGH = CNT_W'(8);

  logic [CNT_W-1:0] reqCnt;
  logic [AMT_W-1:0] effAmt;
  shOp_e            op;

  assign op     = shOp_e'(opSel);
  assign reqCnt = useImm ? CNT_W'(immCnt) : regCnt;

  always_comb begin
    if (reqCnt >= LIM_HIGH)     effAmt = AMT_W'(8);
    else if (reqCnt >= LIM_MID) effAmt = AMT_W'(4);
    else                        effAmt = AMT_W'(reqCnt[1:0]);
  end

  always_comb begin
    ctrl          = '0;
    ctrl.amount   = effAmt;
    ctrl.goRight  = (op == OP_SRL) || (op == OP_SRA);
    ctrl.fillSign = (op == OP_SRA);
    ctrl.doSwap   = (op == OP_SWAP);
    ctrl.flagEn   = (op != OP_SWAP);
  end

  // R3: only the quantized amounts ever reach the datapath
  a_r3_amt_legal: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.amount <= AMT_W'(4)) || (ctrl.amount == AMT_W'(8)));

  // R3: a large requested count always becomes the full 8-place shift
  a_r3_high_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (reqCnt >= LIM_HIGH) |-> (ctrl.amount == AMT_W'(8)));

endmodule

// File: rtl/shswDatapath.sv
module shswDatapath
  import shswPkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int DATA_W  = 24
) (
  input  logic [FIELD_W-1:0] dstField,
  input  logic [FIELD_W-1:0] srcField,
  input  shCtrl_t            ctrl,
  output logic [DATA_W-1:0]  res,
  output logic               carry,
  output logic               zero,
  output logic               neg
);

  localparam int NBYTES = FIELD_W / 8;
  localparam int PAD_W  = DATA_W - FIELD_W;
  localparam int RX_W   = 2 * FIELD_W + 1;

  logic               fillBit;
  logic [RX_W-1:0]    rightExt;
  logic [FIELD_W:0]   leftExt;
  logic [FIELD_W-1:0] swapped;
  logic [FIELD_W-1:0] fieldOut;

  assign fillBit  = ctrl.fillSign & dstField[FIELD_W-1];
  assign rightExt = {{FIELD_W{fillBit}}, dstField, 1'b0} >> ctrl.amount;
  assign leftExt  = {1'b0, dstField} << ctrl.amount;

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign swapped[b*8 +: 8] = srcField[(NBYTES-1-b)*8 +: 8];
  end

  always_comb begin
    if (ctrl.doSwap)       fieldOut = swapped;
    else if (ctrl.goRight) fieldOut = rightExt[FIELD_W:1];
    else                   fieldOut = leftExt[FIELD_W-1:0];
  end

  assign res   = {{PAD_W{1'b0}}, fieldOut};
  assign carry = ctrl.doSwap ? 1'b0 : (ctrl.goRight ? rightExt[0] : leftExt[FIELD_W]);
  assign zero  = ctrl.doSwap ? 1'b0 : (fieldOut == '0);
  assign neg   = ctrl.doSwap ? 1'b0 : fieldOut[FIELD_W-1];

endmodule

// File: rtl/shswUnit.sv
module shswUnit
  import shswPkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int FIELD_W = 16,
  parameter int IMM_W   = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] dstOpnd,
  input  logic [DATA_W-1:0] srcOpnd,
  input  logic [IMM_W-1:0]  immCnt,
  input  logic              useImm,
  output logic [DATA_W-1:0] result,
  output logic              flagC,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagWe
);

  shCtrl_t           ctrl;
  logic [DATA_W-1:0] resNext;
  logic              carryNext, zeroNext, negNext;

  shswCtrl #(.CNT_W(FIELD_W), .IMM_W(IMM_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opSel  (opSel),
    .useImm (useImm),
    .immCnt (immCnt),
    .regCnt (srcOpnd[FIELD_W-1:0]),
    .ctrl   (ctrl)
  );

  shswDatapath #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_dp (
    .dstField (dstOpnd[FIELD_W-1:0]),
    .srcField (srcOpnd[FIELD_W-1:0]),
    .ctrl     (ctrl),
    .res      (resNext),
    .carry    (carryNext),
    .zero     (zeroNext),
    .neg      (negNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      flagC  <= 1'b0;
      flagZ  <= 1'b0;
      flagN  <= 1'b0;
      flagWe <= 1'b0;
    end else begin
      result <= resNext;
      flagC  <= carryNext;
      flagZ  <= zeroNext;
      flagN  <= negNext;
      flagWe <= ctrl.flagEn;
    end
  end

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    result[DATA_W-1:FIELD_W] == '0);

  a_r6_sign_fill: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_SRA && dstOpnd[FIELD_W-1]) |=> result[FIELD_W-1]);

  a_r7_swap_bytes: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_SWAP) |=> (result[7:0] == $past(srcOpnd[15:8])) &&
                           (result[15:8] == $past(srcOpnd[7:0])));

  a_r8_zero_count_no_carry: assert property (@(posedge clk) disable iff (!rstN)
    (useImm && immCnt == '0 && opSel != OP_SWAP) |=> !flagC);

  a_r10_swap_no_flags: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_SWAP) |=> (!flagWe && !flagC && !flagZ && !flagN));

endmodule

// File: tb/shswUnit_tb.sv
module shswUnit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  opSel;
  logic [23:0] dstOpnd, srcOpnd;
  logic [6:0]  immCnt;
  logic        useImm;
  logic [23:0] result;
  logic        flagC, flagZ, flagN, flagWe;

  int nVec  = 0;
  int nFail = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shswUnit u_dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .dstOpnd(dstOpnd), .srcOpnd(srcOpnd),
    .immCnt(immCnt), .useImm(useImm), .result(result), .flagC(flagC),
    .flagZ(flagZ), .flagN(flagN), .flagWe(flagWe)
  );

  // Behavioural reference, written from the requirements
  task automatic model(input logic [1:0] op, input logic [23:0] d, input logic [23:0] s,
                       input logic [6:0] im, input logic ui,
                       output logic [23:0] eRes, output logic eC, output logic eZ,
                       output logic eN, output logic eWe);
    int cnt, k, v, sv, r;
    cnt = ui ? int'(im) : int'(s[15:0]);           // R11, R3
    k   = (cnt < 4) ? cnt : ((cnt < 8) ? 4 : 8);
    v   = int'(d[15:0]);
    eC  = 1'b0;
    if (op == 2'b11) begin                          // R7
      eRes = {8'h00, s[7:0], s[15:8]};
      eZ = 0; eN = 0; eWe = 0;                       // R10
    end else begin
      if (op == 2'b01) begin                         // R5
        r = (v << k) & 32'hFFFF;
        if (k > 0) eC = 1'((v >> (16 - k)) & 1);
      end else begin
        sv = (op == 2'b10 && v >= 32768) ? v - 65536 : v;   // R6 / R4
        r  = (sv >>> k) & 32'hFFFF;
        if (k > 0) eC = 1'((v >> (k - 1)) & 1);
      end
      eRes = {8'h00, 16'(r)};
      eZ = (r == 0); eN = 1'(r >> 15); eWe = 1'b1;
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [23:0] d, input logic [23:0] s,
                       input logic [6:0] im, input logic ui, input string tag);
    logic [23:0] eRes;
    logic eC, eZ, eN, eWe;
    bit bad;
    string rt;
    opSel = op; dstOpnd = d; srcOpnd = s; immCnt = im; useImm = ui;
    model(op, d, s, im, ui, eRes, eC, eZ, eN, eWe);
    @(posedge clk);
    @(negedge clk);
    nVec++;
    bad = 0;
    rt = (op == 2'b00) ? "R4" : (op == 2'b01) ? "R5" : (op == 2'b10) ? "R6" : "R7";
    if (result[23:16] != 8'h00) begin
      bad = 1; $display("FAIL R2 %s upper got %h exp 00", tag, result[23:16]);
    end
    if (result[15:0] != eRes[15:0]) begin
      bad = 1; $display("FAIL %s R3 %s result got %h exp %h", rt, tag, result[15:0], eRes[15:0]);
    end
    if (flagC != eC) begin
      bad = 1; $display("FAIL R8 %s carry got %0b exp %0b", tag, flagC, eC);
    end
    if (flagZ != eZ || flagN != eN) begin
      bad = 1; $display("FAIL R9 %s Z/N got %0b%0b exp %0b%0b", tag, flagZ, flagN, eZ, eN);
    end
    if (flagWe != eWe) begin
      bad = 1; $display("FAIL R10 %s flagWe got %0b exp %0b", tag, flagWe, eWe);
    end
    if (bad) nFail++;
  endtask

  initial begin
    rstN = 0; opSel = 2'b11; dstOpnd = 24'hFFFFFF; srcOpnd = 24'hFFFFFF;
    immCnt = 7'h7F; useImm = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nVec++;
    if (result !== 24'h0 || flagC !== 0 || flagZ !== 0 || flagN !== 0 || flagWe !== 0) begin
      nFail++;
      $display("FAIL R1 reset got %h %0b%0b%0b%0b exp 000000 0000",
               result, flagC, flagZ, flagN, flagWe);
    end
    rstN = 1;

    // R3 R11: sweep counts 0..9 from both sources, all shift ops
    for (int op = 0; op < 3; op++) begin
      for (int c = 0; c < 10; c++) begin
        apply(2'(op), 24'hA5_9C3B, 24'hFF_0000 | 24'(c), 7'h55, 1'b0, "R11 reg sweep");
        apply(2'(op), 24'h77_C3A5, 24'h00_0009, 7'(c), 1'b1, "R11 imm sweep");
      end
    end
    // R3: register counts large, exactly 8, junk in upper bits
    apply(2'b00, 24'h00_8001, 24'h00_FFFF, 7'd0, 1'b0, "R3 huge count");
    apply(2'b10, 24'h00_8001, 24'h00_0008, 7'd0, 1'b0, "R3 count 8");
    apply(2'b01, 24'h00_C001, 24'h3F_0002, 7'd0, 1'b0, "R3 upper ignored");
    apply(2'b01, 24'h12_8000, 24'h0, 7'd1, 1'b1, "R8 carry out of bit15");
    apply(2'b10, 24'hFF_0000, 24'h0, 7'd127, 1'b1, "R9 zero after shift");
    apply(2'b00, 24'h00_0000, 24'h0, 7'd0, 1'b1, "R9 zero count zero val");
    apply(2'b11, 24'hFF_FFFF, 24'hEE_1234, 7'd3, 1'b1, "R7 swap");
    apply(2'b11, 24'h00_0000, 24'hFF_0000, 7'd0, 1'b0, "R7 swap zero");
    apply(2'b10, 24'h00_FFFF, 24'h0, 7'd5, 1'b1, "R6 all ones");

    // random, with half of register counts biased small
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] s;
      s = 24'($urandom);
      if ($urandom_range(1, 0) == 1) s[15:0] = 16'($urandom_range(11, 0));
      apply(2'($urandom), 24'($urandom), s, 7'($urandom), 1'($urandom), "random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R1 watchdog expired got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

endmodule